// File: doc/BRIEF.md
# Masked-Write I2C Pad Control Register

This block is a memory-mapped control register for one open-drain clock pad and one open-drain data pad. Software uses it to bit-bang an I2C bus. Each line has its own direction bit, output-value bit and pull-up-disable bit. The register also shows the sampled level of each pad.

A write carries per-line enable bits, one for the direction and one for the value. A direction or value field changes only when its enable bit is set in that same write. Software can therefore move one line without first reading the register to preserve the other line. The pull-up-disable bits are plain read/write storage, so each write also carries their values. Pad levels pass through a two-flop synchroniser before they reach the readback word. A read returns data one cycle after the request, with `rdValid` high.

Each line occupies an 8-bit lane in a 16-bit word. The clock is lane 0 (bits 7:0) and the data line is lane 1 (bits 15:8). Within a lane, the bit positions are:
- bit 0: pull-up disable, read/write.
- bit 1: direction enable, write-only.
- bit 2: direction, where 1 means drive and 0 means release.
- bit 3: value enable, write-only.
- bit 4: output value.
- bit 5: synchronised pad level, read-only.

All other bits read as 0.

Top module: `i2c_pad_ctrl`

## Requirements
- R1: After reset, both lines are released (`padOe` = 0), both latched output values are 0, and both pull-ups are enabled (`padPullDis` = 0). A read returns 0 in bits 0–4 of each lane.
- R2: A lane's direction bit (lane bit 2) is loaded only by a write that sets that lane's direction enable (lane bit 1). Any other write leaves it unchanged.
- R3: A lane's value bit (lane bit 4) is loaded only by a write that sets that lane's value enable (lane bit 3). Any other write leaves it unchanged.
- R4: A write that sets enables only in one lane leaves the other lane's direction and value unchanged.
- R5: `padOe[i]` is 1 exactly when lane i's direction is 1, and `padOut[i]` equals lane i's value. A line with direction 0 is released and not driven.
- R6: Lane bit 5 reads the pad level through a two-flop synchroniser, whatever the direction. A read issued in the same cycle as a pad change still returns the old level. A read issued three cycles later returns the new level.
- R7: The pull-up-disable bits (lane bit 0) are loaded from every write, drive `padPullDis`, and read back unchanged.
- R8: The enable bits (lane bits 1 and 3) always read back as 0.
- R9: A read issued in the cycle right after a write returns the state written by that write.
- R10: Two writes in sequence leave the line released. The first sets the direction enable with direction 0. The second has no enable bits set and changes no direction or value state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrData | input | 16 | Write word |
| rdEn | input | 1 | Read request |
| rdValid | output | 1 | Read data valid, one cycle after `rdEn` |
| rdData | output | 16 | Read word |
| padIn | input | 2 | Pad levels (bit 0 clock, bit 1 data) |
| padOe | output | 2 | Pad drive enable per line |
| padOut | output | 2 | Pad output value per line |
| padPullDis | output | 2 | Pull-up disable per line |

## Verification
The assertions in the datapath check four rules on every cycle:
- The direction and value bits change only under their enables (R2, R3).
- A line with direction 0 is never driven (R5).
- A write is visible in the state one cycle later (R9).
- The enable bits never appear in read data (R8).

Three behaviours are shown only by the bench's scenarios:
- The synchroniser latency, and the fact that lane bit 5 shows the pad level in either direction (R6).
- The independence of the two lanes (R4).
- The release-then-empty-write sequence (R10).

The bench drives these against an open-drain bus model with an external pull-down.

// File: rtl/i2c_pad_pkg.sv
package i2c_pad_pkg;
  localparam int NUM_LANES   = 2;
  localparam int LANE_STRIDE = 8;
  localparam int REG_W       = NUM_LANES * LANE_STRIDE;
  localparam int BIT_PULLDIS = 0;
  localparam int BIT_DIRMSK  = 1;
  localparam int BIT_DIR     = 2;
  localparam int BIT_VALMSK  = 3;
  localparam int BIT_VAL     = 4;
  localparam int BIT_LEVEL   = 5;
  localparam int SYNC_DEPTH  = 2;

  typedef struct packed {
    logic [NUM_LANES-1:0] dirWe;
    logic [NUM_LANES-1:0] valWe;
    logic [NUM_LANES-1:0] dirNew;
    logic [NUM_LANES-1:0] valNew;
    logic [NUM_LANES-1:0] pullNew;
    logic                 pullWe;
    logic                 rdReq;
  } padStrobeT;
endpackage

// File: rtl/i2c_pad_ctrl_dec.sv
module i2c_pad_ctrl_dec
  import i2c_pad_pkg::*;
(
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdEn,
  output padStrobeT        strb
);
  always_comb begin
    strb        = '0;
    strb.pullWe = wrEn;
    strb.rdReq  = rdEn;
    for (int i = 0; i < NUM_LANES; i++) begin
      strb.dirWe[i]   = wrEn & wrData[i*LANE_STRIDE + BIT_DIRMSK];
      strb.valWe[i]   = wrEn & wrData[i*LANE_STRIDE + BIT_VALMSK];
      strb.dirNew[i]  = wrData[i*LANE_STRIDE + BIT_DIR];
      strb.valNew[i]  = wrData[i*LANE_STRIDE + BIT_VAL];
      strb.pullNew[i] = wrData[i*LANE_STRIDE + BIT_PULLDIS];
    end
  end
endmodule

// File: rtl/i2c_pad_datapath.sv
module i2c_pad_datapath
  import i2c_pad_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  padStrobeT            strb,
  input  logic [NUM_LANES-1:0] padIn,
  output logic [NUM_LANES-1:0] padOe,
  output logic [NUM_LANES-1:0] padOut,
  output logic [NUM_LANES-1:0] padPullDis,
  output logic                 rdValid,
  output logic [REG_W-1:0]     rdData
);
  logic [NUM_LANES-1:0] dirQ, valQ, pullQ;
  logic [NUM_LANES-1:0] syncQ [SYNC_DEPTH];
  logic [REG_W-1:0]     rdWord;

  genvar g;
  generate
    for (g = 0; g < NUM_LANES; g++) begin : gLane
      always_ff @(posedge clk) begin
        if (!rstN) begin
          dirQ[g]  <= 1'b0;
          valQ[g]  <= 1'b0;
          pullQ[g] <= 1'b0;
        end else begin
          if (strb.dirWe[g]) dirQ[g]  <= strb.dirNew[g];
          if (strb.valWe[g]) valQ[g]  <= strb.valNew[g];
          if (strb.pullWe)   pullQ[g] <= strb.pullNew[g];
        end
      end

      always_comb begin
        rdWord[g*LANE_STRIDE +: LANE_STRIDE]           = '0;
        rdWord[g*LANE_STRIDE + BIT_PULLDIS]            = pullQ[g];
        rdWord[g*LANE_STRIDE + BIT_DIR]                = dirQ[g];
        rdWord[g*LANE_STRIDE + BIT_VAL]                = valQ[g];
        rdWord[g*LANE_STRIDE + BIT_LEVEL]              = syncQ[SYNC_DEPTH-1][g];
      end

      // R2: direction holds without its enable
      assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
        !strb.dirWe[g] |=> dirQ[g] == $past(dirQ[g]));
      // R3: value holds without its enable
      assert_val_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
        !strb.valWe[g] |=> valQ[g] == $past(valQ[g]));
      // R9: an enabled write is visible next cycle
      assert_dir_post_R9: assert property (@(posedge clk) disable iff (!rstN)
        strb.dirWe[g] |=> dirQ[g] == $past(strb.dirNew[g]));
      // R5: released line is never driven
      assert_released_R5: assert property (@(posedge clk) disable iff (!rstN)
        !dirQ[g] |-> !padOe[g]);
      // R8: enable bits never reach read data
      assert_mask_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
        rdValid |-> !rdData[g*LANE_STRIDE + BIT_DIRMSK] && !rdData[g*LANE_STRIDE + BIT_VALMSK]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_DEPTH; s++) syncQ[s] <= '1;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_DEPTH; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.rdReq;
      if (strb.rdReq) rdData <= rdWord;
    end
  end

  assign padOe      = dirQ;
  assign padOut     = valQ;
  assign padPullDis = pullQ;
endmodule

// File: rtl/i2c_pad_ctrl.sv
module i2c_pad_ctrl
  import i2c_pad_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [REG_W-1:0]     wrData,
  input  logic                 rdEn,
  output logic                 rdValid,
  output logic [REG_W-1:0]     rdData,
  input  logic [NUM_LANES-1:0] padIn,
  output logic [NUM_LANES-1:0] padOe,
  output logic [NUM_LANES-1:0] padOut,
  output logic [NUM_LANES-1:0] padPullDis
);
  padStrobeT strb;

  i2c_pad_ctrl_dec uDec (
    .wrEn  (wrEn),
    .wrData(wrData),
    .rdEn  (rdEn),
    .strb  (strb)
  );

  i2c_pad_datapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .padIn     (padIn),
    .padOe     (padOe),
    .padOut    (padOut),
    .padPullDis(padPullDis),
    .rdValid   (rdValid),
    .rdData    (rdData)
  );
endmodule

// File: tb/sim_i2c_pad_ctrl.sv
module sim_i2c_pad_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic        rdValid;
  logic [15:0] rdData;
  logic [1:0]  padIn, padOe, padOut, padPullDis;
  logic [1:0]  extLow = 2'b00;

  logic [1:0] mDir = '0, mVal = '0, mPull = '0;
  logic [15:0] expQ[$];
  string       tagQ[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  // open-drain bus model with optional external pull-down
  always_comb
    for (int i = 0; i < 2; i++)
      padIn[i] = extLow[i] ? 1'b0 : (padOe[i] ? padOut[i] : 1'b1);

  i2c_pad_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdValid(rdValid), .rdData(rdData), .padIn(padIn), .padOe(padOe),
    .padOut(padOut), .padPullDis(padPullDis)
  );

  function automatic logic [15:0] expWord(logic [1:0] lvl);
    logic [15:0] w = '0;
    for (int i = 0; i < 2; i++) begin
      w[i*8 + 0] = mPull[i];
      w[i*8 + 2] = mDir[i];
      w[i*8 + 4] = mVal[i];
      w[i*8 + 5] = lvl[i];
    end
    return w;
  endfunction

  function automatic logic [1:0] busLevel();
    logic [1:0] l;
    for (int i = 0; i < 2; i++) l[i] = extLow[i] ? 1'b0 : (mDir[i] ? mVal[i] : 1'b1);
    return l;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    for (int i = 0; i < 2; i++) begin
      if (d[i*8 + 1]) mDir[i] = d[i*8 + 2];
      if (d[i*8 + 3]) mVal[i] = d[i*8 + 4];
      mPull[i] = d[i*8 + 0];
    end
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  // driver: issue a read and push its expected word
  task automatic rdReg(string tag, logic [1:0] lvl);
    expQ.push_back(expWord(lvl));
    tagQ.push_back(tag);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic settleRead(string tag);
    repeat (3) @(negedge clk);
    rdReg(tag, busLevel());
    @(negedge clk);
  endtask

  task automatic checkPads(string tag);
    check({tag, " padOe"},      {14'd0, padOe},      {14'd0, mDir});
    check({tag, " padOut"},     {14'd0, padOut},     {14'd0, mVal});
    check({tag, " padPullDis"}, {14'd0, padPullDis}, {14'd0, mPull});
  endtask

  // monitor: pop and compare as read data arrives
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected read actual=%h expected=none", rdData);
      end else begin
        automatic logic [15:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(t, rdData, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkPads("R1 reset");
    settleRead("R1 reset read");

    // clock driven low via both enables; data lane untouched
    wrReg(16'h000E);
    checkPads("R5 R4 clk low");
    settleRead("R8 R6 clk low read");

    // value without its enable, direction enable with drive
    wrReg(16'h0016);
    checkPads("R3 no val enable");

    // data value enable only
    wrReg(16'h1800);
    checkPads("R2 R4 data val only");
    settleRead("R2 data still released");

    // release clock, then empty write
    wrReg(16'h0002);
    checkPads("R5 clk release");
    wrReg(16'h0000);
    checkPads("R10 empty write");
    settleRead("R10 released read");

    // pull-up disables are stored from each write
    wrReg(16'h0101);
    checkPads("R7 pulls set");
    settleRead("R7 pulls read");
    wrReg(16'h0100);
    checkPads("R7 clk pull cleared");

    // synchroniser latency on an externally pulled-down data line
    begin
      logic [1:0] old;
      @(negedge clk);
      old = busLevel();
      extLow = 2'b10;
      rdReg("R6 old level", old);
      @(negedge clk);
      settleRead("R6 new level");
    end

    // posting read right after a write
    extLow = 2'b11;
    settleRead("R6 both low");
    wrReg(16'h1E0E);
    rdReg("R9 posting read", busLevel());
    @(negedge clk);
    checkPads("R9 pads after post");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R9 missing reads actual=%0d expected=0", expQ.size());
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule